// File: doc/BRIEF.md
# Register-Reference Accumulator Operation Unit

This unit executes the accumulator and extend-bit group of a small accumulator machine. The group is selected when the decode line for opcode 7 is high, the mode bit is low and the timing state is the fourth one (T3). The surrounding control presents the low twelve instruction bits, the current accumulator (AC), the extend bit (E) and the program counter (PC). It raises a strobe while the instruction is active. On the next clock the unit returns the new AC, E and PC values. It also returns write enables for each of them, a request to drop the run flip-flop, and a request to clear the sequence counter.

Each operation is named by a single one-hot instruction bit. There are four operation kinds. Clears and complements act on AC or E. Rotates pass through E. An increment acts on AC. Conditional skips advance PC by one and depend on the sign of AC, on AC being zero, or on E being zero. When the instruction word carries several operation bits, the highest-numbered one wins and an error code reports the conflict. A word with no operation bit also gets an error code and changes nothing.

Top module: `acc_regop_unit`

## Requirements
- R1: An operation fires only when `exec_en`, `dec7` and `tstate3` are all high and `mode_i` is low. In any other cycle, every strobe output (`wr_ac`, `wr_e`, `wr_pc`, `stop_req`, `sc_clear`) is low one cycle later and `err_code` is 0. In that case `ac_out`, `e_out` and `pc_out` keep their previous values.
- R2: All results appear one clock after the firing cycle. At that point `sc_clear` is high for exactly that one cycle. On a firing cycle, `ac_out`, `e_out` and `pc_out` load the new register values, or the unchanged inputs when the operation does not touch a register.
- R3: Bit 11 sets AC to 0. Bit 9 sets AC to its bitwise complement. Both raise `wr_ac`. Bit 10 sets E to 0 and bit 8 inverts E. Both raise `wr_e`.
- R4: Bit 7 rotates right through E. The new AC is {old E, old AC[15:1]} and the new E is old AC[0]. Both `wr_ac` and `wr_e` are raised.
- R5: Bit 6 rotates left through E. The new AC is {old AC[14:0], old E} and the new E is old AC[15]. Both `wr_ac` and `wr_e` are raised.
- R6: Bit 5 sets AC to AC+1, wrapping from 16'hFFFF to 0, and raises `wr_ac`.
- R7: Each skip bit has its own condition. Bit 4 skips when AC[15]=0. Bit 3 skips when AC[15]=1. Bit 2 skips when AC=0. Bit 1 skips when E=0. A taken skip gives `pc_out` = PC+1, modulo 2^12, with `wr_pc` high. A skip not taken gives `pc_out` = PC with `wr_pc` low.
- R8: Bit 0 raises `stop_req` for one cycle and writes no register.
- R9: When more than one of bits 11..0 is set, only the highest-numbered set bit acts, and `err_code` is 2'b10.
- R10: When no operation bit is set on a firing cycle, `err_code` is 2'b01, no write enable or `stop_req` is raised, and `sc_clear` is still high.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Register-reference execute strobe |
| dec7 | input | 1 | Opcode-7 decode line |
| mode_i | input | 1 | Mode (indirect) bit; must be 0 to fire |
| tstate3 | input | 1 | Timing state T3 active |
| ir_lo | input | 12 | Low instruction bits, one-hot operation select |
| ac_in | input | 16 | Current accumulator |
| e_in | input | 1 | Current extend bit |
| pc_in | input | 12 | Current program counter |
| ac_out | output | 16 | New accumulator value |
| e_out | output | 1 | New extend bit |
| pc_out | output | 12 | New program counter |
| wr_ac | output | 1 | Accumulator write enable |
| wr_e | output | 1 | Extend-bit write enable |
| wr_pc | output | 1 | Program counter write enable (skip taken) |
| stop_req | output | 1 | Clear the run flip-flop |
| sc_clear | output | 1 | Clear the sequence counter |
| err_code | output | 2 | 10: several op bits, 01: no op bit, 00: clean |

## Verification
The assertions assume two things about the inputs. First, they hold steady across a clock edge and are never X while reset is released. Second, ac_in, e_in and pc_in describe the state at the firing cycle, so a result can be compared against the values sampled one edge earlier. The stimulus changes inputs only on falling edges. It mixes clean one-hot words, multi-bit words, empty words and non-qualifying control combinations. It also seeds AC with 0, 16'hFFFF and sign-bit values so that every skip condition is seen both taken and not taken.

// File: rtl/acc_regop_unit.sv
module acc_regop_unit #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_en,
  input  logic          dec7,
  input  logic          mode_i,
  input  logic          tstate3,
  input  logic [11:0]   ir_lo,
  input  logic [DW-1:0] ac_in,
  input  logic          e_in,
  input  logic [AW-1:0] pc_in,
  output logic [DW-1:0] ac_out,
  output logic          e_out,
  output logic [AW-1:0] pc_out,
  output logic          wr_ac,
  output logic          wr_e,
  output logic          wr_pc,
  output logic          stop_req,
  output logic          sc_clear,
  output logic [1:0]    err_code
);

  localparam int OPW = 12;

  logic          fire;
  logic [DW-1:0] nx_ac;
  logic          nx_e;
  logic          do_ac, do_e, do_pc, do_halt;
  logic          multi, none;

  assign fire  = exec_en & dec7 & ~mode_i & tstate3;
  assign multi = |(ir_lo & (ir_lo - OPW'(1)));
  assign none  = ~|ir_lo;

  always_comb begin
    nx_ac   = ac_in;
    nx_e    = e_in;
    do_ac   = 1'b0;
    do_e    = 1'b0;
    do_pc   = 1'b0;
    do_halt = 1'b0;
    if (ir_lo[11]) begin
      nx_ac = '0;
      do_ac = 1'b1;
    end else if (ir_lo[10]) begin
      nx_e = 1'b0;
      do_e = 1'b1;
    end else if (ir_lo[9]) begin
      nx_ac = ~ac_in;
      do_ac = 1'b1;
    end else if (ir_lo[8]) begin
      nx_e = ~e_in;
      do_e = 1'b1;
    end else if (ir_lo[7]) begin
      nx_ac = {e_in, ac_in[DW-1:1]};
      nx_e  = ac_in[0];
      do_ac = 1'b1;
      do_e  = 1'b1;
    end else if (ir_lo[6]) begin
      nx_ac = {ac_in[DW-2:0], e_in};
      nx_e  = ac_in[DW-1];
      do_ac = 1'b1;
      do_e  = 1'b1;
    end else if (ir_lo[5]) begin
      nx_ac = ac_in + DW'(1);
      do_ac = 1'b1;
    end else if (ir_lo[4]) begin
      do_pc = ~ac_in[DW-1];
    end else if (ir_lo[3]) begin
      do_pc = ac_in[DW-1];
    end else if (ir_lo[2]) begin
      do_pc = (ac_in == '0);
    end else if (ir_lo[1]) begin
      do_pc = ~e_in;
    end else if (ir_lo[0]) begin
      do_halt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_out   <= '0;
      e_out    <= 1'b0;
      pc_out   <= '0;
      wr_ac    <= 1'b0;
      wr_e     <= 1'b0;
      wr_pc    <= 1'b0;
      stop_req <= 1'b0;
      sc_clear <= 1'b0;
      err_code <= 2'b00;
    end else begin
      wr_ac    <= fire & do_ac;
      wr_e     <= fire & do_e;
      wr_pc    <= fire & do_pc;
      stop_req <= fire & do_halt;
      sc_clear <= fire;
      err_code <= fire ? {multi, none} : 2'b00;
      if (fire) begin
        ac_out <= nx_ac;
        e_out  <= nx_e;
        pc_out <= do_pc ? pc_in + AW'(1) : pc_in;
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_en && dec7 && !mode_i && tstate3) |=>
      !(wr_ac || wr_e || wr_pc || stop_req || sc_clear) && err_code == 2'b00 && $stable(ac_out));

  p_sc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && dec7 && !mode_i && tstate3) |=> sc_clear);

  p_rotr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && dec7 && !mode_i && tstate3 && ir_lo == 12'h080) |=>
      ac_out == {$past(e_in), $past(ac_in[DW-1:1])} && e_out == $past(ac_in[0]));

  p_rotl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && dec7 && !mode_i && tstate3 && ir_lo == 12'h040) |=>
      ac_out == {$past(ac_in[DW-2:0]), $past(e_in)} && e_out == $past(ac_in[DW-1]));

  p_skip_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && dec7 && !mode_i && tstate3 && ir_lo == 12'h004 && ac_in == '0) |=>
      wr_pc && pc_out == $past(pc_in) + AW'(1));

  p_one_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_pc, stop_req, wr_ac | wr_e}));

  p_multi_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && dec7 && !mode_i && tstate3 && $countones(ir_lo) > 1) |=> err_code == 2'b10);

  p_empty_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && dec7 && !mode_i && tstate3 && ir_lo == '0) |=>
      err_code == 2'b01 && !(wr_ac || wr_e || wr_pc || stop_req));

endmodule

// File: tb/acc_regop_unit_test.sv
module acc_regop_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, d7 = 0, md = 0, t3 = 0, e_i = 0;
  logic [11:0] ir = '0, pc_i = '0;
  logic [15:0] ac_i = '0;
  logic [15:0] ac_o; logic e_o; logic [11:0] pc_o;
  logic wa, we, wp, st, sc; logic [1:0] er;

  acc_regop_unit uut (.clk(clk), .rst_n(rst_n), .exec_en(en), .dec7(d7), .mode_i(md),
    .tstate3(t3), .ir_lo(ir), .ac_in(ac_i), .e_in(e_i), .pc_in(pc_i), .ac_out(ac_o),
    .e_out(e_o), .pc_out(pc_o), .wr_ac(wa), .wr_e(we), .wr_pc(wp), .stop_req(st),
    .sc_clear(sc), .err_code(er));

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  bit armed = 0, done = 0;
  logic [15:0] x_ac = '0; logic x_e = 0; logic [11:0] x_pc = '0;
  logic x_wa = 0, x_we = 0, x_wp = 0, x_st = 0, x_sc = 0; logic [1:0] x_er = '0;
  string tag = "R11";

  always @(posedge clk) begin
    int hi, n;
    logic [15:0] a; logic e; logic [11:0] p; logic fa, fe, fp, fs;
    if (!rst_n) begin
      x_ac <= '0; x_e <= 0; x_pc <= '0; x_wa <= 0; x_we <= 0; x_wp <= 0;
      x_st <= 0; x_sc <= 0; x_er <= '0; tag <= "R11"; armed <= 1;
    end else if (en && d7 && !md && t3) begin
      hi = -1;
      for (int k = 0; k < 12; k++) if (ir[k]) hi = k;
      a = ac_i; e = e_i; p = pc_i; fa = 0; fe = 0; fp = 0; fs = 0;
      case (hi)
        11: begin a = 0; fa = 1; tag <= "R3"; end
        10: begin e = 0; fe = 1; tag <= "R3"; end
        9:  begin a = ~ac_i; fa = 1; tag <= "R3"; end
        8:  begin e = ~e_i; fe = 1; tag <= "R3"; end
        7:  begin a = ac_i >> 1; a[15] = e_i; e = ac_i[0]; fa = 1; fe = 1; tag <= "R4"; end
        6:  begin a = ac_i << 1; a[0] = e_i; e = ac_i[15]; fa = 1; fe = 1; tag <= "R5"; end
        5:  begin a = ac_i + 16'd1; fa = 1; tag <= "R6"; end
        4:  begin fp = (ac_i[15] == 0); tag <= "R7"; end
        3:  begin fp = (ac_i[15] == 1); tag <= "R7"; end
        2:  begin fp = (ac_i == 0); tag <= "R7"; end
        1:  begin fp = (e_i == 0); tag <= "R7"; end
        0:  begin fs = 1; tag <= "R8"; end
        default: tag <= "R10";
      endcase
      if (fp) p = pc_i + 12'd1;
      n = $countones(ir);
      if (n > 1) tag <= "R9";
      x_ac <= a; x_e <= e; x_pc <= p; x_wa <= fa; x_we <= fe; x_wp <= fp; x_st <= fs;
      x_sc <= 1; x_er <= {n > 1, n == 0};
    end else begin
      x_wa <= 0; x_we <= 0; x_wp <= 0; x_st <= 0; x_sc <= 0; x_er <= '0; tag <= "R1";
    end
  end

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (armed && !done) begin
    chk(tag, "ac_out", ac_o, x_ac);
    chk(tag, "e_out", 16'(e_o), 16'(x_e));
    chk(tag, "pc_out", 16'(pc_o), 16'(x_pc));
    chk(tag, "write enables", 16'({wa, we, wp, st}), 16'({x_wa, x_we, x_wp, x_st}));
    chk(tag == "R1" ? "R1" : "R2", "sc_clear", 16'(sc), 16'(x_sc));
    chk(tag, "err_code", 16'(er), 16'(x_er));
  end

  task automatic op(logic [11:0] w, logic [15:0] a, logic e, logic [11:0] p,
                    logic q_en = 1, logic q_d7 = 1, logic q_md = 0, logic q_t3 = 1);
    @(negedge clk);
    en = q_en; d7 = q_d7; md = q_md; t3 = q_t3; ir = w; ac_i = a; e_i = e; pc_i = p;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    op(12'h800, 16'h1234, 1, 12'h010);             // R3 clear AC
    op(12'h400, 16'h1234, 1, 12'h010);             // R3 clear E
    op(12'h200, 16'h00F0, 0, 12'h010);             // R3 complement AC
    op(12'h100, 16'h00F0, 0, 12'h010);             // R3 complement E
    op(12'h080, 16'h8001, 0, 12'h020);             // R4
    op(12'h080, 16'h0002, 1, 12'h020);             // R4
    op(12'h040, 16'h8001, 0, 12'h020);             // R5
    op(12'h040, 16'h4000, 1, 12'h020);             // R5
    op(12'h020, 16'hFFFF, 0, 12'h020);             // R6 wrap
    op(12'h010, 16'h7FFF, 0, 12'hFFF);             // R7 taken, PC wraps
    op(12'h010, 16'h8000, 0, 12'h100);             // R7 not taken
    op(12'h008, 16'h8000, 0, 12'h100);             // R7 taken
    op(12'h004, 16'h0000, 0, 12'h100);             // R7 AC zero
    op(12'h004, 16'h0001, 0, 12'h100);             // R7 not taken
    op(12'h002, 16'h0001, 0, 12'h100);             // R7 E zero
    op(12'h002, 16'h0001, 1, 12'h100);             // R7 not taken
    op(12'h001, 16'h0001, 1, 12'h100);             // R8
    op(12'h821, 16'h5555, 1, 12'h100);             // R9 AC clear wins
    op(12'h013, 16'h0000, 0, 12'h100);             // R9 skip wins over halt
    op(12'h000, 16'h5555, 1, 12'h100);             // R10
    op(12'h800, 16'h5555, 1, 12'h100, 1, 1, 1, 1); // R1 mode set
    op(12'h800, 16'h5555, 1, 12'h100, 1, 0, 0, 1); // R1 no decode
    op(12'h800, 16'h5555, 1, 12'h100, 0, 1, 0, 1); // R1 no strobe
    op(12'h800, 16'h5555, 1, 12'h100, 1, 1, 0, 0); // R1 wrong state
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] w;
      case ($urandom_range(0, 3))
        0: w = 12'h000;
        1: w = 12'($urandom);
        default: w = 12'(1) << $urandom_range(0, 11);
      endcase
      op(w, ($urandom_range(0, 3) == 0) ? 16'h0000 : 16'($urandom), 1'($urandom),
         12'($urandom), 1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 7) != 0),
         1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 7) != 0));
    end
    op(12'h000, 16'h0, 0, 12'h0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    #1 done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule